// File: doc/BRIEF.md
# Configurable Synchronous Serial Frame Transmitter

The block turns one character at a time into a serial frame on a single data line, timed by a shared serial clock. The frame shape is chosen at run time for each character: a data length from five to nine bits, a parity mode, and one or two stop bits. A polarity input picks the serial-clock edge on which the line changes, so a receiver can sample on the opposite edge.

In master role the block generates the serial clock from the system clock with a programmable divider and enables its clock output driver. In slave role the serial clock comes in from outside. It is brought into the system clock domain through a two-flop synchroniser and an edge detector. Characters arrive over a valid/ready handshake. A character accepted during the final stop bit of the current frame goes out directly after it, with no idle time between the two frames.

Top module: `sync_frame_tx`

## Requirements
- R1: Each frame opens with one start bit driven low. The data bits follow it, least significant bit first.
- R2: `len_code_i` sets the data length. Codes 0, 1, 2, 3 and 4 give 5, 6, 7, 8 and 9 bits. Codes 5 to 7 give 9 bits. Data bits above the chosen length are neither sent nor counted.
- R3: `parity_i` sets the parity. 0 and 3 mean no parity bit, 1 means even and 2 means odd. When enabled, the parity bit follows the last data bit. It makes the number of ones across the sent data bits and the parity bit even (mode 1) or odd (mode 2).
- R4: Stop bits are driven high. There is one stop bit when `two_stop_i` is 0 and two when it is 1.
- R5: The format and polarity inputs are captured when a character is accepted (`tx_valid_i` and `tx_ready_o` both high). Changing them afterwards has no effect on that frame.
- R6: `tx_ready_o` is high only while the block is idle with nothing pending, or during the last stop bit. It falls in the cycle after an accept. The line is high while idle.
- R7: With `cpol_i` at 0 the line changes only on rising serial-clock edges. With `cpol_i` at 1 it changes only on falling edges.
- R8: When `master_i` is 1, `sclk_oe_o` is 1 and `sclk_o` toggles every `div_i`+1 system clocks. When `master_i` is 0, `sclk_oe_o` is 0 and the block is timed by the synchronised `sclk_i`.
- R9: A character accepted during the last stop bit starts its start bit at the very next change edge, with no idle bit in between.
- R10: After reset the line is high and `tx_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1: generate serial clock, 0: use external clock |
| div_i | input | DIV_W | Master half period minus one, in system clocks |
| cpol_i | input | 1 | Edge select for line changes |
| len_code_i | input | 3 | Data length code |
| parity_i | input | 2 | Parity mode |
| two_stop_i | input | 1 | Two stop bits when high |
| tx_valid_i | input | 1 | Character offered |
| tx_data_i | input | 9 | Character, bit 0 sent first |
| tx_ready_o | output | 1 | Character can be accepted |
| sclk_i | input | 1 | External serial clock (slave role) |
| sclk_o | output | 1 | Generated serial clock (master role) |
| sclk_oe_o | output | 1 | Serial clock output enable |
| txd_o | output | 1 | Serial data line |

## Verification
The hardest case to reach from the ports is the seamless join between two frames. It needs a second character to be accepted inside the short window of the final stop bit, while a free-running clock keeps the frame moving. The bench reaches it by running the sender and a port-level receiver side by side. The sender offers the second character straight after the first accept and waits on ready. The receiver then counts the idle sample edges in front of the next start bit. The capture rule is exercised as well: every table-driven frame has its format and polarity inputs scrambled right after the accept, and the frame must still decode with the original format.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int DATA_W = 9;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF  = 2'd3
  } par_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } st_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    logic       par_bit;
    logic       two_stop;
    logic       pol;
  } fmt_t;
endpackage

// File: rtl/sft_clk.sv
module sft_clk #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic [2:0]       sync_q;
  logic             m_tgl;

  assign m_tgl = master_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!master_i) begin
      cnt_q  <= '0;
    end else if (m_tgl) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // two-flop synchroniser plus history bit for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], sclk_i};
  end

  assign sclk_o = sclk_q;
  assign rise_o = master_i ? (m_tgl && !sclk_q) : (sync_q[1] && !sync_q[2]);
  assign fall_o = master_i ? (m_tgl &&  sclk_q) : (!sync_q[1] && sync_q[2]);
endmodule

// File: rtl/sft_frame.sv
module sft_frame
  import sft_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [2:0]        len_code_i,
  input  logic [1:0]        parity_i,
  input  logic              two_stop_i,
  input  logic              pol_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              txd_o,
  output logic              tick_o
);
  st_e               st_q;
  fmt_t              nxt_fmt_q, cur_fmt_q, fmt_in;
  logic [DATA_W-1:0] nxt_data_q, shreg_q, mask_in;
  logic [3:0]        cnt_q, nb_in;
  logic              loaded_q, act_pol, tick, last_stop, accept;

  assign nb_in = (len_code_i > 3'd4) ? 4'd9 : {1'b0, len_code_i} + 4'd5;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask_in[i] = nb_in > 4'(i);
  end

  always_comb begin
    fmt_in.nbits    = nb_in;
    fmt_in.par_en   = (parity_i == PAR_EVEN) || (parity_i == PAR_ODD);
    fmt_in.par_bit  = (^(data_i & mask_in)) ^ (parity_i == PAR_ODD);
    fmt_in.two_stop = two_stop_i;
    fmt_in.pol      = pol_i;
  end

  // pending character sets the edge while idle, running frame otherwise
  assign act_pol   = (st_q == ST_IDLE) ? nxt_fmt_q.pol : cur_fmt_q.pol;
  assign tick      = act_pol ? fall_i : rise_i;
  assign last_stop = (st_q == ST_STOP) && (cnt_q == {3'd0, cur_fmt_q.two_stop});
  assign ready_o   = !loaded_q && ((st_q == ST_IDLE) || last_stop);
  assign accept    = valid_i && ready_o;
  assign tick_o    = tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      nxt_fmt_q  <= '0;
      cur_fmt_q  <= '0;
      nxt_data_q <= '0;
      shreg_q    <= '0;
      cnt_q      <= '0;
      loaded_q   <= 1'b0;
    end else begin
      if (accept) begin
        nxt_fmt_q  <= fmt_in;
        nxt_data_q <= data_i;
        loaded_q   <= 1'b1;
      end
      if (tick) begin
        unique case (st_q)
          ST_IDLE: begin
            if (loaded_q) begin
              cur_fmt_q <= nxt_fmt_q;
              shreg_q   <= nxt_data_q;
              loaded_q  <= 1'b0;
              st_q      <= ST_START;
            end
          end
          ST_START: begin
            st_q  <= ST_DATA;
            cnt_q <= '0;
          end
          ST_DATA: begin
            shreg_q <= shreg_q >> 1;
            if (cnt_q == cur_fmt_q.nbits - 4'd1) begin
              st_q  <= cur_fmt_q.par_en ? ST_PAR : ST_STOP;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 4'd1;
            end
          end
          ST_PAR: begin
            st_q  <= ST_STOP;
            cnt_q <= '0;
          end
          ST_STOP: begin
            if (!last_stop) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (loaded_q) begin
              cur_fmt_q <= nxt_fmt_q;
              shreg_q   <= nxt_data_q;
              loaded_q  <= 1'b0;
              st_q      <= ST_START;
            end else begin
              st_q <= ST_IDLE;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = shreg_q[0];
      ST_PAR:   txd_o = cur_fmt_q.par_bit;
      default:  txd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sync_frame_tx.sv
module sync_frame_tx
  import sft_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cpol_i,
  input  logic [2:0]        len_code_i,
  input  logic [1:0]        parity_i,
  input  logic              two_stop_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic              txd_o
);
  logic clk_rise, clk_fall, frame_tick;

  sft_clk #(.DIV_W(DIV_W)) i_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .master_i (master_i),
    .div_i    (div_i),
    .sclk_i   (sclk_i),
    .sclk_o   (sclk_o),
    .rise_o   (clk_rise),
    .fall_o   (clk_fall)
  );

  sft_frame i_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (clk_rise),
    .fall_i     (clk_fall),
    .len_code_i (len_code_i),
    .parity_i   (parity_i),
    .two_stop_i (two_stop_i),
    .pol_i      (cpol_i),
    .valid_i    (tx_valid_i),
    .data_i     (tx_data_i),
    .ready_o    (tx_ready_o),
    .txd_o      (txd_o),
    .tick_o     (frame_tick)
  );

  assign sclk_oe_o = master_i;
endmodule

// File: rtl/sft_checker.sv
module sft_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic master_i,
  input logic sclk_i,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic txd_o,
  input logic rise,
  input logic fall,
  input logic tick
);
  a_r6_ready_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> txd_o);

  a_r6_accept_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  a_r7_change_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(txd_o));

  a_r8_slave_rise_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && rise) |-> $past(sclk_i, 2));

  a_r8_slave_fall_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && fall) |-> !$past(sclk_i, 2));
endmodule

bind sync_frame_tx sft_checker i_sft_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .master_i   (master_i),
  .sclk_i     (sclk_i),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o),
  .txd_o      (txd_o),
  .rise       (clk_rise),
  .fall       (clk_fall),
  .tick       (frame_tick)
);

// File: tb/test_sync_frame_tx.sv
`timescale 1ns/1ps
module test_sync_frame_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master = 1'b1;
  logic [7:0] div = 8'd1;
  logic       cpol = 1'b0;
  logic [2:0] len = 3'd3;
  logic [1:0] par = 2'd0;
  logic       two = 1'b0;
  logic       valid = 1'b0;
  logic [8:0] data = '0;
  logic       ready, sclk_o, sclk_oe, txd;
  logic       sclk_i = 1'b0;
  logic       slave_run = 1'b0;

  int checks = 0, fails = 0, viol = 0;
  logic mon_pol = 1'b0, txd_prev = 1'b1, sclk_prev = 1'b0;

  always #2 clk = ~clk;

  sync_frame_tx #(.DIV_W(8)) i_sync_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .div_i(div), .cpol_i(cpol),
    .len_code_i(len), .parity_i(par), .two_stop_i(two), .tx_valid_i(valid),
    .tx_data_i(data), .tx_ready_o(ready), .sclk_i(sclk_i), .sclk_o(sclk_o),
    .sclk_oe_o(sclk_oe), .txd_o(txd)
  );

  // external serial clock, half period of 8 system clocks
  always begin
    repeat (8) @(negedge clk);
    if (slave_run) sclk_i = ~sclk_i;
  end

  // R7 monitor: in master role txd may change only where sclk_o reaches the change level
  always @(negedge clk) begin
    if (rst_n && master && txd !== txd_prev &&
        !(sclk_o !== sclk_prev && sclk_o == !mon_pol)) viol++;
    txd_prev  = txd;
    sclk_prev = sclk_o;
  end

  typedef struct packed {
    logic [2:0] len; logic [1:0] par; logic two; logic pol; logic mst; logic [8:0] data;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{3'd3, 2'd0, 1'b0, 1'b0, 1'b1, 9'h0A5},
    '{3'd0, 2'd1, 1'b0, 1'b0, 1'b1, 9'h015},
    '{3'd1, 2'd2, 1'b1, 1'b1, 1'b1, 9'h02A},
    '{3'd2, 2'd1, 1'b1, 1'b1, 1'b1, 9'h07F},
    '{3'd4, 2'd2, 1'b0, 1'b0, 1'b1, 9'h1C3},
    '{3'd4, 2'd1, 1'b1, 1'b1, 1'b1, 9'h155},
    '{3'd3, 2'd3, 1'b0, 1'b0, 1'b1, 9'h0FF},
    '{3'd0, 2'd1, 1'b0, 1'b0, 1'b1, 9'h1E1},
    '{3'd3, 2'd2, 1'b0, 1'b1, 1'b0, 9'h03C},
    '{3'd4, 2'd1, 1'b1, 1'b0, 1'b0, 9'h101},
    '{3'd6, 2'd2, 1'b0, 1'b1, 1'b0, 9'h0E7}
  };

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_samp(input logic pol);
    logic prev, cur;
    prev = master ? sclk_o : sclk_i;
    forever begin
      @(negedge clk);
      cur = master ? sclk_o : sclk_i;
      if (cur != prev && cur == pol) break;
      prev = cur;
    end
  endtask

  task automatic send(input vec_t v, input logic scramble);
    @(negedge clk);
    len = v.len; par = v.par; two = v.two; cpol = v.pol; data = v.data;
    mon_pol = v.pol; valid = 1'b1;
    while (!ready) @(negedge clk);
    @(negedge clk);
    valid = 1'b0;
    if (scramble) begin
      len = ~len; par = ~par; two = ~two; cpol = ~cpol; data = ~data;
    end
  endtask

  task automatic recv(input logic pol, input int nb, input logic pen, input int ns,
                      output logic [8:0] d, output logic p, output logic sok, output int gap);
    d = '0; p = 1'b0; sok = 1'b1; gap = 0;
    wait_samp(pol);
    while (txd !== 1'b0 && gap < 200) begin gap++; wait_samp(pol); end
    for (int i = 0; i < nb; i++) begin wait_samp(pol); d[i] = txd; end
    if (pen) begin wait_samp(pol); p = txd; end
    for (int i = 0; i < ns; i++) begin wait_samp(pol); if (txd !== 1'b1) sok = 1'b0; end
  endtask

  function automatic int nbits(input logic [2:0] c);
    return (c > 3'd4) ? 9 : int'(c) + 5;
  endfunction

  function automatic logic [8:0] mask_of(input int nb);
    return 9'h1FF >> (9 - nb);
  endfunction

  logic [8:0] rd, rd2;
  logic       rp, rp2, rs, rs2;
  int         rg, rg2;

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL all: watchdog expired, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(txd === 1'b1, "R10", "txd in reset", txd, 1);
    check(ready === 1'b1, "R10", "ready in reset", ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(txd === 1'b1 && ready === 1'b1, "R10", "idle after reset", {txd, ready}, 3);
    check(sclk_oe === 1'b1, "R8", "oe in master", sclk_oe, 1);

    // R8 divider half period
    for (int k = 1; k <= 3; k += 2) begin
      int n;
      logic s0;
      div = 8'(k);
      repeat (12) @(negedge clk);
      s0 = sclk_o;
      while (sclk_o == s0) @(negedge clk);
      s0 = sclk_o; n = 0;
      while (sclk_o == s0) begin @(negedge clk); n++; end
      check(n == k + 1, "R8", "half period", n, k + 1);
    end
    div = 8'd1;

    // table: R1 R2 R3 R4 R5 R7, slave rows cover R8
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int nb;
      logic [8:0] md;
      logic ep;
      v = VEC[i];
      if (v.mst != master) begin
        master = v.mst;
        slave_run = !v.mst;
        repeat (40) @(negedge clk);
        check(sclk_oe === v.mst, "R8", "oe per role", sclk_oe, v.mst);
      end
      nb = nbits(v.len);
      md = v.data & mask_of(nb);
      ep = (^md) ^ (v.par == 2'd2);
      send(v, 1'b1);
      check(ready === 1'b0, "R6", "ready after accept", ready, 0);
      recv(v.pol, nb, (v.par == 2'd1 || v.par == 2'd2), v.two ? 2 : 1, rd, rp, rs, rg);
      check(rd == md, "R1 R2 R5", "data bits", rd, md);
      if (v.par == 2'd1 || v.par == 2'd2)
        check(rp == ep, "R3", "parity bit", rp, ep);
      check(rs, "R4", "stop bits high", rs, 1);
      repeat (20) @(negedge clk);
      check(ready === 1'b1 && txd === 1'b1, "R6", "idle after frame", {ready, txd}, 3);
    end

    // R9 back-to-back frames in master role
    master = 1'b1; slave_run = 1'b0;
    repeat (10) @(negedge clk);
    fork
      begin
        send('{3'd3, 2'd1, 1'b0, 1'b0, 1'b1, 9'h0C3}, 1'b0);
        send('{3'd3, 2'd1, 1'b0, 1'b0, 1'b1, 9'h05A}, 1'b0);
      end
      begin
        recv(1'b0, 8, 1'b1, 1, rd, rp, rs, rg);
        recv(1'b0, 8, 1'b1, 1, rd2, rp2, rs2, rg2);
      end
    join
    check(rd == 9'h0C3 && rd2 == 9'h05A, "R9", "both characters", {rd2, rd}, {9'h05A, 9'h0C3});
    check(rg2 == 0, "R9", "idle bits between frames", rg2, 0);
    check(rp == 1'b0 && rp2 == 1'b0, "R3", "even parity pair", {rp2, rp}, 0);

    check(viol == 0, "R7", "txd changes off the change edge", viol, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule